// File: doc/BRIEF.md
# Sample-Rate Mode Select and Restart Sequencer

This control block decides whether the audio path runs at normal, double or quad speed and makes every change of that decision safe for the output stage. The decision draws on three inputs: a board-level speed pin, a two-bit speed field written over the control bus, and, when the chip receives its clocks from elsewhere, a measurement of how many master-clock cycles fit into one frame-clock period. Quad speed is detected automatically in clock-slave operation. In clock-master operation it comes only from the speed field.

When the resolved mode differs from the mode in force, the block runs a fixed restart sequence. It first forces the PWM outputs into hard mute. It then holds the processing core in reset and keeps the control-bus slave suspended for a set number of cycles. Next it asks for a partial re-initialization and waits for a done flag or a cycle limit. After one unmute cycle it returns to idle. The block itself stores no register contents, so the settings held by the control registers are unaffected by the sequence. A new mode change during the sequence sends it back to the mute step.

Top module: `rate_restart_ctrl`

## Requirements
- R1: After reset, speed_o is 00 and busy_o, hard_mute_o, proc_reset_o, bus_hold_o and reinit_req_o are all low.
- R2: speed_o encodes 00 = normal, 01 = double, 10 = quad. On rate_sel_i, 00 follows dbl_pin_i (low gives normal, high gives double), 01 forces normal and 10 forces double. In clock-slave mode, 11 counts as "double not selected".
- R3: With is_master_i high, quad is selected if and only if rate_sel_i is 11. Otherwise the choice follows R2, and the frame clock has no effect on the mode.
- R4: With is_master_i low and double not selected, the mode is quad when the accepted frame-period measurement lies within RATIO plus or minus RATIO_TOL master-clock cycles (126 to 130 by default), and normal otherwise.
- R5: The accepted measurement changes only when two consecutive frame periods both disagree with it. A single deviating period leaves the mode unchanged and starts no sequence.
- R6: When the resolved mode differs from speed_o while idle, busy_o rises one cycle later. The mute step (1 cycle) and the reset hold (HOLD_CYC cycles) both drive proc_reset_o high. speed_o takes the new value as the hold begins.
- R7: After the hold, reinit_req_o stays high until reinit_done_i is seen high or REINIT_MAX cycles have passed. One unmute cycle then follows, so busy_o lasts HOLD_CYC + 2 + (reinit cycles).
- R8: While busy_o is high, hard_mute_o is high, every pwm_p_o bit is 0, every pwm_m_o bit is 1 and every pwm_valid_o bit is 0.
- R9: bus_hold_o is high during the mute, hold and reinit steps, which is every busy cycle except the unmute cycle.
- R10: If the resolved mode changes away from the sequence target mid-sequence, the sequence restarts at the mute step without dropping busy_o.
- R11: While idle, pwm_p_o, pwm_m_o and pwm_valid_o equal pwm_p_i, pwm_m_i and pwm_valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master_i | input | 1 | 1 = block generates the audio clocks, 0 = receives them |
| dbl_pin_i | input | 1 | Speed pin: low normal, high double |
| rate_sel_i | input | 2 | Speed field from control register |
| frame_clk_i | input | 1 | Frame (left/right) clock, synchronized inside |
| reinit_done_i | input | 1 | Partial re-initialization finished |
| pwm_p_i | input | NCH | Positive PWM outputs from the modulator |
| pwm_m_i | input | NCH | Negative PWM outputs from the modulator |
| pwm_valid_i | input | NCH | Valid flags from the modulator |
| speed_o | output | 2 | Mode in force |
| busy_o | output | 1 | Restart sequence in progress |
| hard_mute_o | output | 1 | Hard mute applied |
| proc_reset_o | output | 1 | Reset to the processing core |
| bus_hold_o | output | 1 | Suspend control-bus accesses |
| reinit_req_o | output | 1 | Partial re-initialization request |
| pwm_p_o | output | NCH | Gated positive outputs |
| pwm_m_o | output | NCH | Gated negative outputs |
| pwm_valid_o | output | NCH | Gated valid flags |

## Verification
The bench builds the block with NCH = 2, HOLD_CYC = 4 and REINIT_MAX = 6, with the ratio left at 128 plus or minus 2. The short phases let the bench count the cycles of every restart exactly, both when the done flag ends re-initialization and when the timeout does, and let it place a mid-sequence change at a known step. The frame period is swept from 122 to 134 cycles, which covers both edges of the detection window. A one-frame glitch and the master-mode case check that the measurement is used only where it should be.

// File: rtl/rate_pkg.sv
package rate_pkg;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10
  } speed_e;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_MUTE   = 3'd1,
    SQ_HOLD   = 3'd2,
    SQ_REINIT = 3'd3,
    SQ_UNMUTE = 3'd4
  } seq_e;

  localparam logic [1:0] SEL_FOLLOW = 2'b00;
  localparam logic [1:0] SEL_NORMAL = 2'b01;
  localparam logic [1:0] SEL_DOUBLE = 2'b10;
  localparam logic [1:0] SEL_QUAD   = 2'b11;

endpackage

// File: rtl/rate_ratio_meter.sv
// Measures master-clock cycles per frame-clock period and qualifies
// the "near RATIO" verdict over two consecutive frames.
module rate_ratio_meter #(
  parameter int RATIO = 128,
  parameter int TOL   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_i,
  output logic quad_o
);

  localparam int CW = $clog2(RATIO + TOL + 2) + 1;
  localparam logic [CW-1:0] LO_LIM = CW'(RATIO - TOL);
  localparam logic [CW-1:0] HI_LIM = CW'(RATIO + TOL);
  localparam logic [CW-1:0] SAT    = {CW{1'b1}};

  logic [2:0]    sync_q;
  logic          rise_w;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          seen_q;
  logic          acc_q, acc_d;
  logic          pend_q, pend_d;
  logic          take_w;
  logic          near_w;

  assign rise_w = sync_q[1] & ~sync_q[2];
  assign near_w = (cnt_q >= LO_LIM) && (cnt_q <= HI_LIM);
  assign take_w = rise_w & seen_q;

  always_comb begin
    cnt_en = rise_w | (cnt_q != SAT);
    cnt_d  = rise_w ? CW'(1) : cnt_q + CW'(1);
  end

  always_comb begin
    acc_d  = acc_q;
    pend_d = pend_q;
    if (near_w == acc_q) begin
      pend_d = 1'b0;
    end else if (pend_q) begin
      acc_d  = near_w;
      pend_d = 1'b0;
    end else begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], frame_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else if (rise_w) begin
      seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (take_w) begin
      acc_q  <= acc_d;
      pend_q <= pend_d;
    end
  end

  assign quad_o = acc_q;

endmodule

// File: rtl/rate_mode_resolve.sv
// Combines pin, register field, clock role and measured ratio.
module rate_mode_resolve
  import rate_pkg::*;
(
  input  logic       is_master_i,
  input  logic       dbl_pin_i,
  input  logic [1:0] rate_sel_i,
  input  logic       auto_quad_i,
  output speed_e     mode_o
);

  logic want_dbl;

  always_comb begin
    want_dbl = (rate_sel_i == SEL_DOUBLE) ||
               ((rate_sel_i == SEL_FOLLOW) && dbl_pin_i);
    if (is_master_i) begin
      if (rate_sel_i == SEL_QUAD) mode_o = SPD_QUAD;
      else if (want_dbl)          mode_o = SPD_DOUBLE;
      else                        mode_o = SPD_NORMAL;
    end else begin
      if (want_dbl)               mode_o = SPD_DOUBLE;
      else if (auto_quad_i)       mode_o = SPD_QUAD;
      else                        mode_o = SPD_NORMAL;
    end
  end

endmodule

// File: rtl/rate_seq_fsm.sv
// Mute / reset-hold / reinit / unmute sequencer with mid-sequence restart.
module rate_seq_fsm
  import rate_pkg::*;
#(
  parameter int HOLD_CYC   = 16,
  parameter int REINIT_MAX = 64
) (
  input  logic   clk,
  input  logic   rst_n,
  input  speed_e want_i,
  input  logic   done_i,
  output speed_e speed_o,
  output seq_e   state_o
);

  localparam int LIM = (HOLD_CYC > REINIT_MAX) ? HOLD_CYC : REINIT_MAX;
  localparam int CW  = $clog2(LIM + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] RE_LAST   = CW'(REINIT_MAX - 1);

  seq_e          st_q, st_d;
  speed_e        cur_q, tgt_q;
  logic          cur_en, tgt_en;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          restart_w;

  assign restart_w = (st_q != SQ_IDLE) && (want_i != tgt_q);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cur_en = 1'b0;
    tgt_en = 1'b0;
    if (restart_w) begin
      st_d   = SQ_MUTE;
      tgt_en = 1'b1;
      cnt_d  = '0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (want_i != cur_q) begin
            st_d   = SQ_MUTE;
            tgt_en = 1'b1;
          end
        end
        SQ_MUTE: begin
          st_d   = SQ_HOLD;
          cur_en = 1'b1;
          cnt_d  = HOLD_LAST;
        end
        SQ_HOLD: begin
          if (cnt_q == '0) begin
            st_d  = SQ_REINIT;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        SQ_REINIT: begin
          if (done_i || (cnt_q == RE_LAST)) begin
            st_d  = SQ_UNMUTE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        SQ_UNMUTE: st_d = SQ_IDLE;
        default:   st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= SPD_NORMAL;
    end else if (tgt_en) begin
      tgt_q <= want_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= SPD_NORMAL;
    end else if (cur_en) begin
      cur_q <= tgt_q;
    end
  end

  assign speed_o = cur_q;
  assign state_o = st_q;

endmodule

// File: rtl/rate_out_gate.sv
// Forces the hard-mute pattern on each output channel.
module rate_out_gate #(
  parameter int NCH = 6
) (
  input  logic           mute_i,
  input  logic [NCH-1:0] p_i,
  input  logic [NCH-1:0] m_i,
  input  logic [NCH-1:0] v_i,
  output logic [NCH-1:0] p_o,
  output logic [NCH-1:0] m_o,
  output logic [NCH-1:0] v_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign p_o[c] = mute_i ? 1'b0 : p_i[c];
    assign m_o[c] = mute_i ? 1'b1 : m_i[c];
    assign v_o[c] = mute_i ? 1'b0 : v_i[c];
  end

endmodule

// File: rtl/rate_restart_ctrl.sv
module rate_restart_ctrl
  import rate_pkg::*;
#(
  parameter int NCH        = 6,
  parameter int HOLD_CYC   = 16,
  parameter int REINIT_MAX = 64,
  parameter int RATIO      = 128,
  parameter int RATIO_TOL  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           is_master_i,
  input  logic           dbl_pin_i,
  input  logic [1:0]     rate_sel_i,
  input  logic           frame_clk_i,
  input  logic           reinit_done_i,
  input  logic [NCH-1:0] pwm_p_i,
  input  logic [NCH-1:0] pwm_m_i,
  input  logic [NCH-1:0] pwm_valid_i,
  output logic [1:0]     speed_o,
  output logic           busy_o,
  output logic           hard_mute_o,
  output logic           proc_reset_o,
  output logic           bus_hold_o,
  output logic           reinit_req_o,
  output logic [NCH-1:0] pwm_p_o,
  output logic [NCH-1:0] pwm_m_o,
  output logic [NCH-1:0] pwm_valid_o
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       auto_quad;
  speed_e     want_mode;
  speed_e     cur_mode;
  seq_e       seq_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  rate_ratio_meter #(
    .RATIO (RATIO),
    .TOL   (RATIO_TOL)
  ) u_meter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .frame_i (frame_clk_i),
    .quad_o  (auto_quad)
  );

  rate_mode_resolve u_resolve (
    .is_master_i (is_master_i),
    .dbl_pin_i   (dbl_pin_i),
    .rate_sel_i  (rate_sel_i),
    .auto_quad_i (auto_quad),
    .mode_o      (want_mode)
  );

  rate_seq_fsm #(
    .HOLD_CYC   (HOLD_CYC),
    .REINIT_MAX (REINIT_MAX)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .want_i  (want_mode),
    .done_i  (reinit_done_i),
    .speed_o (cur_mode),
    .state_o (seq_state)
  );

  assign speed_o      = cur_mode;
  assign busy_o       = (seq_state != SQ_IDLE);
  assign hard_mute_o  = busy_o;
  assign proc_reset_o = (seq_state == SQ_MUTE) || (seq_state == SQ_HOLD);
  assign bus_hold_o   = (seq_state == SQ_MUTE) || (seq_state == SQ_HOLD) ||
                        (seq_state == SQ_REINIT);
  assign reinit_req_o = (seq_state == SQ_REINIT);

  rate_out_gate #(
    .NCH (NCH)
  ) u_gate (
    .mute_i (hard_mute_o),
    .p_i    (pwm_p_i),
    .m_i    (pwm_m_i),
    .v_i    (pwm_valid_i),
    .p_o    (pwm_p_o),
    .m_o    (pwm_m_o),
    .v_o    (pwm_valid_o)
  );

endmodule

// File: rtl/rate_restart_ctrl_chk.sv
module rate_restart_ctrl_chk #(
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           live_n,
  input logic           is_master_i,
  input logic [1:0]     rate_sel_i,
  input logic [1:0]     speed_o,
  input logic           busy_o,
  input logic           hard_mute_o,
  input logic           proc_reset_o,
  input logic           bus_hold_o,
  input logic           reinit_req_o,
  input logic [NCH-1:0] pwm_p_o,
  input logic [NCH-1:0] pwm_m_o,
  input logic [NCH-1:0] pwm_valid_o
);

  assert_mute_pattern_R8: assert property (@(posedge clk) disable iff (!live_n)
    busy_o |-> (hard_mute_o && pwm_p_o == '0 && pwm_m_o == '1 && pwm_valid_o == '0));

  assert_bus_in_seq_R9: assert property (@(posedge clk) disable iff (!live_n)
    bus_hold_o |-> busy_o);

  assert_reset_holds_bus_R9: assert property (@(posedge clk) disable iff (!live_n)
    proc_reset_o |-> bus_hold_o);

  assert_start_in_reset_R6: assert property (@(posedge clk) disable iff (!live_n)
    $rose(busy_o) |-> proc_reset_o);

  assert_speed_moves_busy_R6: assert property (@(posedge clk) disable iff (!live_n)
    !$stable(speed_o) |-> busy_o);

  assert_reinit_after_reset_R7: assert property (@(posedge clk) disable iff (!live_n)
    reinit_req_o |-> (!proc_reset_o && busy_o));

  assert_speed_code_R2: assert property (@(posedge clk) disable iff (!live_n)
    speed_o != 2'b11);

  assert_reg_double_R2: assert property (@(posedge clk) disable iff (!live_n)
    (!busy_o && rate_sel_i == 2'b10) |=> (busy_o || speed_o == 2'b01));

  assert_master_quad_R3: assert property (@(posedge clk) disable iff (!live_n)
    (!busy_o && is_master_i && rate_sel_i == 2'b11) |=> (busy_o || speed_o == 2'b10));

endmodule

bind rate_restart_ctrl rate_restart_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk          (clk),
  .live_n       (rst_sync_n),
  .is_master_i  (is_master_i),
  .rate_sel_i   (rate_sel_i),
  .speed_o      (speed_o),
  .busy_o       (busy_o),
  .hard_mute_o  (hard_mute_o),
  .proc_reset_o (proc_reset_o),
  .bus_hold_o   (bus_hold_o),
  .reinit_req_o (reinit_req_o),
  .pwm_p_o      (pwm_p_o),
  .pwm_m_o      (pwm_m_o),
  .pwm_valid_o  (pwm_valid_o)
);

// File: tb/rate_restart_ctrl_test.sv
module rate_restart_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 2;
  localparam int HOLD = 4;
  localparam int RMAX = 6;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           is_master, dbl_pin, frame_clk, done;
  logic [1:0]     rate_sel;
  logic [NCH-1:0] p_i, m_i, v_i;
  logic [1:0]     speed;
  logic           busy, hmute, prst, bhold, rreq;
  logic [NCH-1:0] p_o, m_o, v_o;

  int checks = 0;
  int errors = 0;
  int busy_len, prst_n, rreq_n, bh_n, mute_bad;
  int fr_per = 0;
  int fr_next = 0;
  bit busy_seen = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rate_restart_ctrl #(
    .NCH(NCH), .HOLD_CYC(HOLD), .REINIT_MAX(RMAX)
  ) uut (
    .clk(clk), .rst_n(rst_n), .is_master_i(is_master), .dbl_pin_i(dbl_pin),
    .rate_sel_i(rate_sel), .frame_clk_i(frame_clk), .reinit_done_i(done),
    .pwm_p_i(p_i), .pwm_m_i(m_i), .pwm_valid_i(v_i),
    .speed_o(speed), .busy_o(busy), .hard_mute_o(hmute), .proc_reset_o(prst),
    .bus_hold_o(bhold), .reinit_req_o(rreq),
    .pwm_p_o(p_o), .pwm_m_o(m_o), .pwm_valid_o(v_o)
  );

  always @(negedge clk) if (busy) busy_seen = 1'b1;

  // frame clock generator: rising edge every fr_per cycles
  initial begin
    frame_clk = 1'b0;
    forever begin
      if (fr_per == 0) begin
        frame_clk = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        p = (fr_next != 0) ? fr_next : fr_per;
        fr_next = 0;
        frame_clk = 1'b1;
        repeat (p / 2) @(negedge clk);
        frame_clk = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_seq(input int flip_at, input logic flip_pin);
    busy_len = 0; prst_n = 0; rreq_n = 0; bh_n = 0; mute_bad = 0;
    @(negedge clk);
    while (busy && busy_len < 200) begin
      busy_len++;
      if (prst)  prst_n++;
      if (rreq)  rreq_n++;
      if (bhold) bh_n++;
      if (!hmute || p_o != '0 || m_o != '1 || v_o != '0) mute_bad++;
      if (busy_len == flip_at) dbl_pin = flip_pin;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    rst_n = 1'b0; is_master = 1'b0; dbl_pin = 1'b0; rate_sel = 2'b00;
    done = 1'b1; p_i = '1; m_i = '0; v_i = '1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 speed", int'(speed), 0);
    chk("R1 controls", int'({busy, hmute, prst, bhold, rreq}), 0);
    // R11 pass-through when idle
    chk("R11 p", int'(p_o), 3);
    chk("R11 m", int'(m_o), 0);
    chk("R11 v", int'(v_o), 3);

    // pin high selects double, full sequence with immediate done
    dbl_pin = 1'b1;
    run_seq(0, 1'b0);
    chk("R7 busy length", busy_len, HOLD + 3);
    chk("R6 reset cycles", prst_n, HOLD + 1);
    chk("R7 reinit cycles", rreq_n, 1);
    chk("R9 bus hold cycles", bh_n, HOLD + 2);
    chk("R8 mute pattern", mute_bad, 0);
    chk("R2 pin double", int'(speed), 1);

    // register forces normal over pin high
    rate_sel = 2'b01;
    run_seq(0, 1'b0);
    chk("R2 reg normal", int'(speed), 0);
    chk("R8 mute pattern reg", mute_bad, 0);

    // register forces double over pin low
    dbl_pin = 1'b0; rate_sel = 2'b10;
    run_seq(0, 1'b0);
    chk("R2 reg double", int'(speed), 1);

    // slave code 11 without quad ratio gives normal
    rate_sel = 2'b11;
    run_seq(0, 1'b0);
    chk("R2 slave code 11", int'(speed), 0);

    // no change: no sequence
    busy_seen = 1'b0; rate_sel = 2'b00;
    repeat (10) @(negedge clk);
    chk("R6 no change no seq", int'(busy_seen), 0);
    chk("R11 idle p", int'(p_o), 3);

    // reinit timeout
    done = 1'b0; dbl_pin = 1'b1;
    run_seq(0, 1'b0);
    chk("R7 timeout length", busy_len, HOLD + 2 + RMAX);
    chk("R7 timeout reinit", rreq_n, RMAX);
    chk("R9 timeout bus hold", bh_n, HOLD + 1 + RMAX);
    chk("R2 double again", int'(speed), 1);

    // restart mid-sequence: go to normal, flip back to double in hold
    dbl_pin = 1'b0;
    run_seq(3, 1'b1);
    chk("R10 restart length", busy_len, 3 + HOLD + 2 + RMAX);
    chk("R10 reset cycles", prst_n, 3 + HOLD + 1);
    chk("R10 final speed", int'(speed), 1);
    chk("R8 restart mute", mute_bad, 0);
    done = 1'b1;

    // master mode quad from register
    is_master = 1'b1; dbl_pin = 1'b0; rate_sel = 2'b11;
    run_seq(0, 1'b0);
    chk("R3 master quad", int'(speed), 2);

    // master mode ignores frame ratio
    rate_sel = 2'b00; fr_per = 128;
    run_seq(0, 1'b0);
    chk("R3 master normal", int'(speed), 0);
    busy_seen = 1'b0;
    repeat (8 * 128) @(negedge clk);
    chk("R3 frame ignored speed", int'(speed), 0);
    chk("R3 frame ignored busy", int'(busy_seen), 0);

    // slave sweep across the detection window
    is_master = 1'b0;
    for (int per = 122; per <= 134; per++) begin
      fr_per = per;
      repeat (6 * per + 40) @(negedge clk);
      chk($sformatf("R4 sweep period %0d", per), int'(speed),
          (per >= 126 && per <= 130) ? 2 : 0);
      chk("R4 sweep settled", int'(busy), 0);
    end

    // back to quad, then a single glitch period
    fr_per = 128;
    repeat (6 * 128 + 40) @(negedge clk);
    chk("R4 quad at 128", int'(speed), 2);
    busy_seen = 1'b0;
    fr_next = 64;
    repeat (4 * 128) @(negedge clk);
    chk("R5 glitch speed", int'(speed), 2);
    chk("R5 glitch no seq", int'(busy_seen), 0);

    // double overrides automatic quad in slave mode
    dbl_pin = 1'b1;
    run_seq(0, 1'b0);
    chk("R4 double over auto", int'(speed), 1);

    // slave code 11 with quad ratio gives quad
    dbl_pin = 1'b0; rate_sel = 2'b11;
    run_seq(0, 1'b0);
    chk("R4 slave code 11 quad", int'(speed), 2);

    // pass-through with a mixed pattern
    p_i = 2'b01; m_i = 2'b10; v_i = 2'b01;
    @(negedge clk);
    chk("R11 mixed p", int'(p_o), 1);
    chk("R11 mixed m", int'(m_o), 2);
    chk("R11 mixed v", int'(v_o), 1);

    summary();
  end

endmodule